// File: doc/BRIEF.md
# Ideal Compare Status Unit

A combinational comparator that orders a destination operand against a source operand. It returns three status flags: less, equal and greater. The flags follow the true mathematical ordering of the two values at the selected width. They stay correct even in cases where subtracting the operands at that width would overflow.

A size code selects the operand width: 8, 16, 32 or 64 bits. A mode input picks signed (two's complement) or unsigned ordering.

A separate strobe supports a byte semaphore operation. When that operation is requested, the strobe asserts if the source byte is smaller than the destination byte. This tells the surrounding datapath to copy the destination byte over the source location. The memory write itself belongs to the caller.

Top module: `cmp_status`

## Requirements
- R1: Exactly one of `lt_o`, `eq_o`, `gt_o` is high for every combination of inputs.
- R2: In signed mode, `lt_o` is high when the destination is less than the source, `eq_o` when they are equal, and `gt_o` when the destination is greater, comparing two's complement values of the selected width.
- R3: The ordering is exact even where `dst - src` overflows at the selected width. For example, at 8 bits signed, 0x7F against 0x80 gives greater, and 0x80 against 0x01 gives less.
- R4: With `unsigned_i` high, operands are ordered as unsigned values, so the top bit of the selected width adds magnitude instead of sign. For example, at 8 bits, 0x80 against 0x7F gives greater.
- R5: `size_i` selects the width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Only the low bits of that width take part in the comparison.
- R6: Operand bits above the selected width have no effect on any output.
- R7: With `stgb_i` high, `store_o` is high exactly when the low source byte, read as signed, is less than the low destination byte, read as signed. This holds regardless of `size_i` and `unsigned_i`.
- R8: With `stgb_i` low, `store_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand |
| size_i | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| unsigned_i | input | 1 | 1 selects unsigned ordering |
| stgb_i | input | 1 | Requests the byte store-if-greater decision |
| lt_o | output | 1 | Destination less than source |
| eq_o | output | 1 | Operands equal |
| gt_o | output | 1 | Destination greater than source |
| store_o | output | 1 | Write the destination byte over the source |

## Verification
Every pair of byte values is compared in both modes, with random junk in the upper bits, at the width where overflow and sign handling matter most. A design that derives the flags from the sign of a plain difference would report the wrong order for pairs such as 0x7F/0x80. A design that ignores the mode would swap the order of any pair whose top bits differ.

The wider widths are driven with random values and with the extremes: zero, all ones, most-negative and most-positive. These catch a width decoder that takes the wrong sign bit, or that leaks upper bits into the result. The strobe is checked over the full byte sweep while size and mode are varied. A design that reused the main flags, or compared the bytes unsigned, would raise the strobe on the wrong pairs.

// File: rtl/cmp_status.sv
module cmp_status #(
  parameter int W = 64
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic [1:0]   size_i,
  input  logic         unsigned_i,
  input  logic         stgb_i,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o,
  output logic         store_o
);
  localparam int XW = W + 1;

  logic [XW-1:0] dx, sx;

  function automatic logic [XW-1:0] widen(input logic [W-1:0] v, input logic [1:0] sz, input logic u);
    logic [XW-1:0] r;
    case (sz)
      2'b00:   r = {{(XW-8){~u & v[7]}},   v[7:0]};
      2'b01:   r = {{(XW-16){~u & v[15]}}, v[15:0]};
      2'b10:   r = {{(XW-32){~u & v[31]}}, v[31:0]};
      default: r = {~u & v[W-1], v};
    endcase
    return r;
  endfunction

  assign dx = widen(dst_i, size_i, unsigned_i);
  assign sx = widen(src_i, size_i, unsigned_i);

  assign eq_o = (dx == sx);
  assign lt_o = $signed(dx) < $signed(sx);
  assign gt_o = ~eq_o & ~lt_o;

  assign store_o = stgb_i & ($signed(src_i[7:0]) < $signed(dst_i[7:0]));
endmodule

module cmp_status_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] dst_i,
  input logic [W-1:0] src_i,
  input logic [1:0]   size_i,
  input logic         unsigned_i,
  input logic         stgb_i,
  input logic         lt_o,
  input logic         eq_o,
  input logic         gt_o,
  input logic         store_o
);
  logic [W-1:0] mask;
  always_comb begin
    case (size_i)
      2'b00:   mask = W'(8'hFF);
      2'b01:   mask = W'(16'hFFFF);
      2'b10:   mask = W'(32'hFFFF_FFFF);
      default: mask = '1;
    endcase
  end

  always_comb begin
    p_onehot_r1: assert ($countones({lt_o, eq_o, gt_o}) == 1)
      else $error("R1 status not one-hot");
    p_eq_r5: assert (eq_o == ((dst_i & mask) == (src_i & mask)))
      else $error("R5 equality does not follow selected width");
    p_uns_zero_r4: assert (!(unsigned_i && (dst_i & mask) == '0) || !gt_o)
      else $error("R4 unsigned zero reported greater");
    p_no_strobe_r8: assert (stgb_i || !store_o)
      else $error("R8 strobe without request");
    p_strobe_gt_r7: assert (!(store_o && size_i == 2'b00 && !unsigned_i) || gt_o)
      else $error("R7 strobe disagrees with signed byte order");
  end
endmodule

bind cmp_status cmp_status_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cmp_status.sv
module sim_cmp_status;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] dst, src;
  logic [1:0]  size;
  logic        uns, stgb;
  logic        lt, eq, gt, st;

  int errors = 0;
  int checks = 0;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  cmp_status u0 (
    .dst_i(dst), .src_i(src), .size_i(size), .unsigned_i(uns), .stgb_i(stgb),
    .lt_o(lt), .eq_o(eq), .gt_o(gt), .store_o(st)
  );

  function automatic logic [63:0] step(input logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  function automatic logic signed [65:0] val(input logic [63:0] x, input int n, input bit u);
    logic signed [65:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i] = x[i];
    if (!u && x[n-1]) v = v - (66'sd1 <<< n);
    return v;
  endfunction

  task automatic check(input logic [63:0] d, input logic [63:0] s, input logic [1:0] z,
                       input bit u, input bit g, input string tag);
    int n;
    logic signed [65:0] vd, vs;
    logic [2:0] exp_f;
    logic exp_s;
    dst = d; src = s; size = z; uns = u; stgb = g;
    #1;
    n = 8 << z;
    vd = val(d, n, u);
    vs = val(s, n, u);
    exp_f = {vd < vs, vd == vs, vd > vs};
    exp_s = g && (val(s, 8, 0) < val(d, 8, 0));
    checks++;
    if ({lt, eq, gt} !== exp_f) begin
      errors++;
      $display("FAIL %s flags d=%h s=%h size=%0d u=%0d actual=%b expected=%b",
               tag, d, s, z, u, {lt, eq, gt}, exp_f);
    end
    checks++;
    if (st !== exp_s) begin
      errors++;
      $display("FAIL %s strobe d=%h s=%h stgb=%0d actual=%b expected=%b",
               tag, d, s, g, st, exp_s);
    end
  endtask

  initial begin
    dst = '0; src = '0; size = 2'b00; uns = 1'b0; stgb = 1'b0;
    #2;
    checks++;
    if ({lt, eq, gt, st} !== 4'b0100) begin
      errors++;
      $display("FAIL R1 initial actual=%b expected=0100", {lt, eq, gt, st});
    end
    // R3 overflow corners
    check(64'h7F, 64'h80, 2'b00, 0, 1, "R3");
    check(64'h80, 64'h01, 2'b00, 0, 1, "R3");
    // R4 unsigned top bit
    check(64'h80, 64'h7F, 2'b00, 1, 0, "R4");
    // R2 R4 R6 R7 R8: exhaustive byte sweep with junk above
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int u = 0; u < 2; u++) begin
          lfsr = step(lfsr);
          check({lfsr[63:8], a[7:0]}, {lfsr[55:0], b[7:0]}, 2'b00, u[0],
                ((a + b) % 3) != 0, u ? "R4_R6_R8" : "R2_R6_R7");
        end
      end
    end
    // R5: wider widths, random and extreme
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] d, s;
      lfsr = step(lfsr); d = lfsr;
      lfsr = step(lfsr); s = lfsr;
      if (k % 5 == 0) s[31:0] = d[31:0];
      if (k % 7 == 0) s[15:0] = d[15:0];
      check(d, s, 2'(k % 4), k[2], k[3], "R5_R6");
    end
    for (int z = 1; z < 4; z++) begin
      logic [63:0] mx, mn;
      mx = 64'h7FFF_FFFF_FFFF_FFFF >> (64 - (8 << z));
      mn = 64'h8000_0000_0000_0000 >> (64 - (8 << z));
      check(mx, mn, 2'(z), 0, 1, "R3");
      check(mn, mx, 2'(z), 0, 0, "R3");
      check(mn, mx, 2'(z), 1, 0, "R4");
      check(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'(z), 1, 1, "R4_R7");
      check(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'(z), 0, 1, "R2");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule